// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the low address bits of a synchronous burst memory. It tracks a start value and a beat count, and produces the word address inside an aligned four-word block. The order is chosen by a static order-select input. In linear order the count is added to the start value, so the address wraps inside the block. In interleaved order the count is combined with the start value by XOR.

A burst begins when an address strobe qualifies on a rising clock edge. There are two strobes. The processor strobe loads only when the primary enable is also low. The controller strobe loads on its own. When neither strobe loads, the advance input decides what happens: low moves to the next beat, high inserts a wait cycle that keeps the current address. The load indication is combinational and tells the upper address register to capture on the same edge. The upper bits themselves are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe active, burst_addr_o reads 2'b00.
- R2: With ads_proc_ni low and ce_ni low at a rising edge, the value on addr_lo_i is loaded. With ads_proc_ni low and ce_ni high, no load takes place, and the advance input behaves as if neither strobe were active.
- R3: With ads_ctrl_ni low at a rising edge, the value on addr_lo_i is loaded whatever the level of ce_ni.
- R4: upper_load_o is high during any cycle in which a load qualifies, and low otherwise. After a loading edge, burst_addr_o equals the loaded value.
- R5: With mode_i low (linear order) and start s, the nth beat address is (s + n) mod 4. For example, start 2'b01 gives 01, 10, 11, 00.
- R6: With mode_i high (interleaved order) and start s, the nth beat address is s XOR n. For example, start 2'b10 gives 10, 11, 00, 01.
- R7: With no load and adv_ni high at a rising edge, burst_addr_o holds its value (a wait cycle).
- R8: If both strobes qualify on the same edge, one load takes place. It overrides advance, and the beat count restarts at zero.
- R9: An advance after the fourth beat wraps back to the start address and stays inside the four-word block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_proc_ni | input | 1 | Processor address strobe, active low, gated by ce_ni |
| ads_ctrl_ni | input | 1 | Controller address strobe, active low, ungated |
| ce_ni | input | 1 | Primary chip enable, active low |
| adv_ni | input | 1 | Burst advance, active low; high inserts a wait |
| mode_i | input | 1 | Order select: 0 linear, 1 interleaved (static) |
| addr_lo_i | input | 2 | External low address bits loaded as start value |
| burst_addr_o | output | 2 | Current low address of the burst |
| upper_load_o | output | 1 | Capture enable for the upper address register |

## Verification
The hardest case to reach from the ports is a wait cycle or a qualifying strobe that lands in the middle of a burst, after the count has already wrapped. Each table vector loads one start value in one order and then applies eight cycles with an irregular advance pattern. This places waits at different beat positions and makes the count pass the block boundary. Directed cycles follow. They raise the processor strobe with the enable high in mid-burst, drive both strobes together with advance low, and apply reset in mid-burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic ads_proc_ni,
  input  logic ads_ctrl_ni,
  input  logic ce_ni,
  input  logic adv_ni,
  output logic load_o,
  output logic step_o
);
  logic proc_hit, ctrl_hit;

  assign proc_hit = ~ads_proc_ni & ~ce_ni;
  assign ctrl_hit = ~ads_ctrl_ni;
  assign load_o   = proc_hit | ctrl_hit;
  // load wins over advance
  assign step_o   = ~load_o & ~adv_ni;
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [BEAT_W-1:0] start_i,
  output logic [BEAT_W-1:0] start_o,
  output logic [BEAT_W-1:0] cnt_o
);
  localparam logic [BEAT_W-1:0] CNT_LAST = {BEAT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= '0;
      cnt_o   <= '0;
    end else if (load_i) begin
      start_o <= start_i;
      cnt_o   <= '0;
    end else if (step_i) begin
      cnt_o   <= cnt_o + 1'b1;
    end
  end

  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && cnt_o == CNT_LAST) |=> cnt_o == '0);

  a_r7_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> ($stable(cnt_o) && $stable(start_o)));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] cnt_i,
  output logic [BEAT_W-1:0] addr_o
);
  logic [BEAT_W-1:0] lin_addr, ilv_addr;

  assign lin_addr = start_i + cnt_i;
  assign ilv_addr = start_i ^ cnt_i;

  always_comb begin
    unique case (order_i)
      ORD_LINEAR:     addr_o = lin_addr;
      ORD_INTERLEAVE: addr_o = ilv_addr;
      default:        addr_o = lin_addr;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ads_proc_ni,
  input  logic              ads_ctrl_ni,
  input  logic              ce_ni,
  input  logic              adv_ni,
  input  logic              mode_i,
  input  logic [BEAT_W-1:0] addr_lo_i,
  output logic [BEAT_W-1:0] burst_addr_o,
  output logic              upper_load_o
);
  logic              load, step;
  logic [BEAT_W-1:0] start_q, cnt_q;
  order_e            order_q;

  // order select is static but sampled each edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) order_q <= ORD_LINEAR;
    else         order_q <= order_e'(mode_i);
  end

  burst_load_ctrl u_load (
    .ads_proc_ni (ads_proc_ni),
    .ads_ctrl_ni (ads_ctrl_ni),
    .ce_ni       (ce_ni),
    .adv_ni      (adv_ni),
    .load_o      (load),
    .step_o      (step)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .start_i (addr_lo_i),
    .start_o (start_q),
    .cnt_o   (cnt_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i (order_q),
    .start_i (start_q),
    .cnt_i   (cnt_q),
    .addr_o  (burst_addr_o)
  );

  assign upper_load_o = load;

  a_r2_proc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_ni && !ce_ni) |=> burst_addr_o == $past(addr_lo_i));

  a_r3_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_ctrl_ni |=> burst_addr_o == $past(addr_lo_i));

  a_r5_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upper_load_o && !adv_ni && !mode_i && order_q == ORD_LINEAR)
      |=> burst_addr_o == BEAT_W'($past(burst_addr_o) + 1'b1));

  a_r6_interleave_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upper_load_o && !adv_ni && mode_i && order_q == ORD_INTERLEAVE)
      |=> burst_addr_o == ($past(start_q) ^ BEAT_W'($past(cnt_q) + 1'b1)));

  a_r7_addr_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upper_load_o && adv_ni && (order_q == order_e'(mode_i)))
      |=> $stable(burst_addr_o));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ps_n = 1'b1, cs_n = 1'b1, ce_n = 1'b1, adv_n = 1'b1, mode = 1'b0;
  logic [1:0] lo = 2'b00;
  logic [1:0] addr;
  logic       ld;

  int n_vec = 0;
  int n_bad = 0;
  logic [1:0] m_start = '0, m_cnt = '0;

  always #4 clk = ~clk;

  burst_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .ads_proc_ni(ps_n), .ads_ctrl_ni(cs_n),
    .ce_ni(ce_n), .adv_ni(adv_n), .mode_i(mode), .addr_lo_i(lo),
    .burst_addr_o(addr), .upper_load_o(ld)
  );

  // {mode, start, advance mask (1 = advance)}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'b00, 8'b1111_1111},
    {1'b0, 2'b01, 8'b1011_0111},
    {1'b0, 2'b10, 8'b1101_1101},
    {1'b0, 2'b11, 8'b0111_1110},
    {1'b1, 2'b00, 8'b1111_1111},
    {1'b1, 2'b01, 8'b1110_1011},
    {1'b1, 2'b10, 8'b1011_1101},
    {1'b1, 2'b11, 8'b0110_1111}
  };

  function automatic logic [1:0] exp_addr();
    return mode ? (m_start ^ m_cnt) : 2'(m_start + m_cnt);
  endfunction

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, check load_o, then output 2 ns after posedge
  task automatic cyc(input logic p, input logic c, input logic e, input logic a,
                     input logic [1:0] l, input string tag);
    logic exp_ld;
    @(negedge clk);
    ps_n = p; cs_n = c; ce_n = e; adv_n = a; lo = l;
    #1;
    exp_ld = (!p && !e) || !c;
    chk({1'b0, ld}, {1'b0, exp_ld}, {tag, "/R4 load"});
    if (exp_ld) begin m_start = l; m_cnt = 2'b00; end
    else if (!a) m_cnt = m_cnt + 2'b01;
    @(posedge clk);
    #2;
    chk(addr, exp_addr(), tag);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #3;
    chk(addr, 2'b00, "R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 1, 1, 1, 2'b11, "R1 idle after reset");

    for (int i = 0; i < 8; i++) begin
      mode = VEC[i][10];
      if (i % 2 == 0) cyc(0, 1, 0, 1, VEC[i][9:8], "R2 proc load");
      else            cyc(1, 0, 1, 1, VEC[i][9:8], "R3 ctrl load");
      for (int k = 7; k >= 0; k--)
        cyc(1, 1, 1, !VEC[i][k], 2'b00, mode ? "R6 interleave beat" : "R5 linear beat");
    end

    // R9 explicit wrap: four advances return to start
    mode = 1'b0;
    cyc(1, 0, 0, 1, 2'b10, "R3 load start 10");
    for (int k = 0; k < 4; k++) cyc(1, 1, 1, 0, 2'b00, "R9 wrap");
    chk(addr, 2'b10, "R9 back at start");

    // R2 gated strobe ignored mid-burst: wait then advance
    cyc(0, 1, 1, 1, 2'b01, "R2 gated proc strobe wait");
    chk(addr, 2'b10, "R2 addr unchanged");
    cyc(0, 1, 1, 0, 2'b01, "R2 gated proc strobe advance");
    chk(addr, 2'b11, "R2 advanced not loaded");

    // R8 both strobes with advance low
    mode = 1'b1;
    cyc(1, 1, 1, 1, 2'b00, "R7 wait before R8");
    cyc(0, 0, 0, 0, 2'b01, "R8 both strobes");
    chk(addr, 2'b01, "R8 single load");
    cyc(1, 1, 1, 0, 2'b00, "R8 count restarted");
    chk(addr, 2'b00, "R8 next beat 01^1");

    // R7 long wait
    cyc(1, 1, 1, 1, 2'b11, "R7 wait a");
    cyc(1, 1, 1, 1, 2'b11, "R7 wait b");

    // R1 reset mid-burst
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(addr, 2'b00, "R1 reset mid-burst");
    @(negedge clk);
    rst_n = 1'b1;
    m_start = 2'b00; m_cnt = 2'b00; mode = 1'b0;
    cyc(1, 1, 1, 0, 2'b00, "R1 advance after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule